// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block is a full-duplex SPI master. Software sets it up through a small register bus: it picks the character length, the clock polarity, the sampling phase and the bit order. It then queues characters into a transmit FIFO and collects received characters from a receive FIFO. Each character is shifted out on MOSI and sampled from MISO. The serial clock is paced by a half-period tick from a separate prescaler block.

Characters are 4 to 16 bits long, or a whole 32-bit word. Their position inside the 32-bit bus words depends on the bit order. An event register holds live FIFO status and sticky error and completion flags. A mask register turns selected flags into an interrupt. A slave-select register drives active-low select lines. A loopback bit routes the transmitted bit stream back into the receiver.

Top module: `spi_master_core`

Register addresses on `bus_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | mode | read / write |
| 1 | event | read, write 1 to clear |
| 2 | mask | read / write |
| 3 | command | write |
| 4 | transmit data | write |
| 5 | receive data | read |
| 6 | slave select | read / write |

## Requirements
- R1: After reset all slave-select lines are high, SCK is low, the interrupt is low, and the event register (address 1) reads 0x1 (only transmit-room set).
- R2: Mode bits [11:8] hold the character length minus one, and values below 3 are treated as a 4-bit length. Mode bit 5 selects 32-bit characters that use the whole word.
- R3: With mode bit 3 set (MSB first), an N-bit character is taken from bits [31:32-N] of the transmit word and sent most significant bit first. It is returned in bits [15+N:16] of the receive word. A 32-bit character keeps its place in the word.
- R4: With mode bit 3 clear (LSB first), the character is taken from bits [N-1:0] and sent least significant bit first. It is returned in bits [15:16-N] of the receive word.
- R5: Mode bit 1 sets the SCK idle level. Mode bit 2 selects sampling on the leading edge (0) or the trailing edge (1) of each bit period. SCK only changes on a tick during a transfer.
- R6: While the enable bit (mode bit 0) is set, a mode write changes only the enable bit.
- R7: A write to the transmit data address while the block is disabled is discarded and causes no transfer.
- R8: In the event register, bit 0 (transmit FIFO not full) and bit 1 (receive FIFO not empty) are live. Bits 2 (overrun), 3 (underrun), 4 (select conflict) and 5 (last done) are sticky and are cleared by writing 1 to them. Reading receive data while the receive FIFO is empty returns 0 and sets underrun.
- R9: When a character completes while the receive FIFO is full, the character is discarded and overrun is set. The characters already stored are kept in their order.
- R10: With mode bit 4 set, the receiver samples MOSI internally and ignores the MISO pin. With it clear, the receiver samples MISO.
- R11: `irq` is the registered OR of the event bits ANDed with the mask register (address 2), which uses the same bit positions.
- R12: The slave-select register (address 6) drives `ss_n` directly from its low SS_COUNT bits, so slave k is selected by clearing only bit k-1.
- R13: If `ext_sel_n` goes low while the block is enabled, the select-conflict flag is set and the enable bit is cleared.
- R14: Writing 1 to command bit 0 (address 3) arms a marker. When a character completes and the transmit FIFO is empty, the last-done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| sck_tick | input | 1 | Half-period pulse from the prescaler |
| ext_sel_n | input | 1 | External select, active low; low while enabled is a conflict |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | SS_COUNT | Active-low slave selects |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and SS_COUNT = 4. The shallow receive FIFO lets five back-to-back loopback characters reach the overrun case and the discard of the fifth character. The four select lines are enough to show that clearing one bit selects a single slave. The bench pulses `sck_tick` every second clock, so even a 32-bit character finishes in about 130 cycles. This leaves room to cover both bit orders, the clamped 4-bit length, the 16-bit and 32-bit placements, and a non-zero clock polarity with trailing-edge sampling. A monitor records the MOSI bit on every sampling edge, which checks the wire order independently of the receive path.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int WORD_W = 32;
  localparam int EV_W   = 6;

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_EVENT = 3'd1;
  localparam logic [2:0] A_MASK  = 3'd2;
  localparam logic [2:0] A_CMD   = 3'd3;
  localparam logic [2:0] A_TXD   = 3'd4;
  localparam logic [2:0] A_RXD   = 3'd5;
  localparam logic [2:0] A_SSEL  = 3'd6;

  typedef struct packed {
    logic [3:0] len_m1;
    logic       wide;
    logic       loop;
    logic       msb;
    logic       cpha;
    logic       cpol;
    logic       en;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.en     = w[0];
    c.cpol   = w[1];
    c.cpha   = w[2];
    c.msb    = w[3];
    c.loop   = w[4];
    c.wide   = w[5];
    c.len_m1 = w[11:8];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[0]     = c.en;
    w[1]     = c.cpol;
    w[2]     = c.cpha;
    w[3]     = c.msb;
    w[4]     = c.loop;
    w[5]     = c.wide;
    w[11:8]  = c.len_m1;
    return w;
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    cnt;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;

  // R9
  push_full_chk: assert property (@(posedge clk) disable iff (rst) !(push && full));
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst) !(pop && empty));
  // R9
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (level == $past(level) + LW'(1)));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 32,
  localparam int NBW = $clog2(WORD_W) + 1,
  localparam int EW  = NBW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [NBW-1:0]    nbits,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              msb,
  input  logic              loop,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_raw,
  output logic              sck,
  output logic              mosi
);

  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic [EW-1:0]     edge_q, last_edge;
  logic [NBW-1:0]    n_q;
  logic              sck_q, mosi_q, miso_i;
  logic              sample_now, shift_now;

  assign last_edge  = {n_q, 1'b0} - EW'(1);
  assign miso_i     = loop ? mosi_q : miso;
  assign sample_now = cpha ? edge_q[0] : !edge_q[0];
  assign shift_now  = cpha ? (!edge_q[0] && edge_q != '0)
                           : (edge_q[0] && edge_q != last_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      edge_q <= '0;
      n_q    <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck_q <= cpol;
        if (start) begin
          busy   <= 1'b1;
          edge_q <= '0;
          n_q    <= nbits;
          rx_sh  <= '0;
          mosi_q <= msb ? tx_word[WORD_W-1] : tx_word[0];
          tx_sh  <= msb ? (tx_word << 1) : (tx_word >> 1);
        end
      end else if (tick) begin
        edge_q <= edge_q + EW'(1);
        sck_q  <= !sck_q;
        if (sample_now)
          rx_sh <= msb ? {rx_sh[WORD_W-2:0], miso_i} : {miso_i, rx_sh[WORD_W-1:1]};
        if (shift_now) begin
          mosi_q <= msb ? tx_sh[WORD_W-1] : tx_sh[0];
          tx_sh  <= msb ? (tx_sh << 1) : (tx_sh >> 1);
        end
        if (edge_q == last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign rx_raw = rx_sh;
  assign sck    = sck_q;
  assign mosi   = mosi_q;

  // R5
  sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sck));
  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (sck == $past(cpol)));

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core #(
  parameter int FIFO_DEPTH = 4,
  parameter int SS_COUNT   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [2:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                sck_tick,
  input  logic                ext_sel_n,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic [SS_COUNT-1:0] ss_n,
  output logic                irq
);
  import spim_pkg::*;

  localparam int NBW  = $clog2(WORD_W) + 1;
  localparam int HALF = WORD_W / 2;
  localparam int LW   = $clog2(FIFO_DEPTH + 1);

  cfg_t                cfg_q;
  logic [EV_W-1:0]     mask_q, ev_vec;
  logic                ev_ovr, ev_und, ev_mme, ev_lst, last_arm;
  logic [SS_COUNT-1:0] ss_q;
  logic [WORD_W-1:0]   rdata_q, rd_val, rx_word, rx_raw, tx_dout, rx_dout;
  logic                irq_q;
  logic                wr, rd, tx_push, rx_push, rx_pop, start;
  logic                tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0]       tx_level, rx_level;
  logic                eng_busy, eng_done;
  logic [NBW-1:0]      nbits;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign tx_push = wr && bus_addr == A_TXD && cfg_q.en && !tx_full;
  assign start   = cfg_q.en && !eng_busy && !tx_empty;
  assign rx_push = eng_done && !rx_full;
  assign rx_pop  = rd && bus_addr == A_RXD && !rx_empty;

  always_comb begin
    if (cfg_q.wide)             nbits = NBW'(WORD_W);
    else if (cfg_q.len_m1 < 4'd3) nbits = NBW'(4);
    else                        nbits = NBW'(cfg_q.len_m1) + NBW'(1);
  end

  always_comb begin
    if (cfg_q.wide)     rx_word = rx_raw;
    else if (cfg_q.msb) rx_word = rx_raw << HALF;
    else                rx_word = rx_raw >> HALF;
  end

  spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata), .pop(start),
    .dout(tx_dout), .full(tx_full), .empty(tx_empty), .level(tx_level));

  spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_dout), .full(rx_full), .empty(rx_empty), .level(rx_level));

  spim_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .tick(sck_tick), .start(start), .tx_word(tx_dout),
    .nbits(nbits), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .msb(cfg_q.msb),
    .loop(cfg_q.loop), .miso(miso), .busy(eng_busy), .done(eng_done),
    .rx_raw(rx_raw), .sck(sck), .mosi(mosi));

  assign ev_vec = {ev_lst, ev_mme, ev_und, ev_ovr, !rx_empty, !tx_full};

  always_comb begin
    case (bus_addr)
      A_MODE:  rd_val = cfg_to_word(cfg_q);
      A_EVENT: rd_val = WORD_W'(ev_vec);
      A_MASK:  rd_val = WORD_W'(mask_q);
      A_RXD:   rd_val = rx_empty ? '0 : rx_dout;
      A_SSEL:  rd_val = WORD_W'(ss_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      mask_q   <= '0;
      ev_ovr   <= 1'b0;
      ev_und   <= 1'b0;
      ev_mme   <= 1'b0;
      ev_lst   <= 1'b0;
      last_arm <= 1'b0;
      ss_q     <= '1;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q   <= |(ev_vec & mask_q);
      rdata_q <= rd ? rd_val : '0;
      if (wr) begin
        case (bus_addr)
          A_MODE: begin
            if (cfg_q.en) cfg_q.en <= bus_wdata[0];
            else          cfg_q    <= cfg_from_word(bus_wdata);
          end
          A_EVENT: begin
            if (bus_wdata[2]) ev_ovr <= 1'b0;
            if (bus_wdata[3]) ev_und <= 1'b0;
            if (bus_wdata[4]) ev_mme <= 1'b0;
            if (bus_wdata[5]) ev_lst <= 1'b0;
          end
          A_MASK:  mask_q <= bus_wdata[EV_W-1:0];
          A_CMD:   if (bus_wdata[0]) last_arm <= 1'b1;
          A_SSEL:  ss_q <= bus_wdata[SS_COUNT-1:0];
          default: ;
        endcase
      end
      if (rd && bus_addr == A_RXD && rx_empty) ev_und <= 1'b1;
      if (eng_done && rx_full) ev_ovr <= 1'b1;
      if (eng_done && tx_empty && last_arm) begin
        ev_lst   <= 1'b1;
        last_arm <= 1'b0;
      end
      if (cfg_q.en && !ext_sel_n) begin
        ev_mme   <= 1'b1;
        cfg_q.en <= 1'b0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign ss_n      = ss_q;
  assign irq       = irq_q;

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.en |=> $stable(cfg_q[9:1]));
  // R7
  drop_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == A_TXD && !cfg_q.en) |=> $stable(tx_level));
  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && rx_full) |=> (ev_ovr && $stable(rx_level)));
  // R8
  under_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == A_RXD && rx_empty) |=> ev_und);
  // R12
  ss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && bus_addr == A_SSEL) |=> $stable(ss_n));
  // R13
  mm_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.en && !ext_sel_n) |=> (!cfg_q.en && ev_mme));

endmodule

// File: tb/spi_master_core_test.sv
module spi_master_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck_tick = 1'b0;
  logic        ext_sel_n = 1'b1;
  logic        miso = 1'b1;
  logic        sck, mosi, irq;
  logic [3:0]  ss_n;

  int chk_cnt = 0;
  int fail_cnt = 0;
  bit finished = 1'b0;

  logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic        prev_sck = 1'b0;
  logic [31:0] mon_bits = '0;
  int          mon_cnt = 0;

  always #10 clk = !clk;

  spi_master_core #(.FIFO_DEPTH(4), .SS_COUNT(4)) uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick),
    .ext_sel_n(ext_sel_n), .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n), .irq(irq));

  initial begin
    forever begin
      @(negedge clk);
      sck_tick = !sck_tick;
    end
  end

  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      if ((sck != mon_cpol) ^ mon_cpha) begin
        mon_bits <= {mon_bits[30:0], mosi};
        mon_cnt  <= mon_cnt + 1;
      end
    end
    prev_sck <= sck;
  end

  function automatic logic [31:0] md(input bit cpol, cpha, msb, loop, wide,
                                     input int len);
    logic [31:0] w;
    w = '0;
    w[1] = cpol; w[2] = cpha; w[3] = msb; w[4] = loop; w[5] = wide;
    w[11:8] = 4'(len - 1);
    return w;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_mode(input logic [31:0] m);
    bus_write(3'd0, 32'h0);
    mon_cpol = m[1];
    mon_cpha = m[2];
    bus_write(3'd0, m & ~32'h1);
    bus_write(3'd0, m | 32'h1);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_rx(input string tag);
    logic [31:0] e;
    bit got;
    got = 1'b0;
    for (int i = 0; i < 600; i++) begin
      bus_read(3'd1, e);
      if (e[1]) begin got = 1'b1; break; end
    end
    chk(32'(got), 32'd1, tag);
  endtask

  task automatic xfer(input logic [31:0] m, input logic [31:0] txw,
                      input logic [31:0] exp_rx, input logic [31:0] exp_wire,
                      input int nb, input string tag);
    logic [31:0] d, wmask;
    int base;
    set_mode(m);
    base = mon_cnt;
    bus_write(3'd4, txw);
    wait_rx(tag);
    bus_read(3'd5, d);
    chk(d, exp_rx, tag);
    if (nb > 0) begin
      wmask = (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
      chk(32'(mon_cnt - base), 32'(nb), {tag, " bit count"});
      chk(mon_bits & wmask, exp_wire, {tag, " wire order"});
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(32'(ss_n), 32'hF, "R1 ss_n after reset");
    chk(32'(sck), 32'h0, "R1 sck after reset");
    chk(32'(irq), 32'h0, "R1 irq after reset");
    bus_read(3'd1, d);
    chk(d, 32'h1, "R1 event after reset");
  endtask

  task automatic t_disabled_tx();
    logic [31:0] d;
    bus_write(3'd0, 32'h0);
    bus_write(3'd4, 32'h1234_5678);
    set_mode(md(0, 0, 1, 1, 0, 8));
    repeat (200) @(negedge clk);
    bus_read(3'd1, d);
    chk(d & 32'h2, 32'h0, "R7 no data after disabled write");
  endtask

  task automatic t_orders();
    xfer(md(0, 0, 1, 1, 0, 8), 32'hC100_0000, 32'h00C1_0000, 32'hC1, 8, "R3 msb 8-bit");
    xfer(md(0, 0, 0, 1, 0, 8), 32'h0000_00C1, 32'h0000_C100, 32'h83, 8, "R4 lsb 8-bit");
    xfer(md(0, 0, 0, 1, 0, 16), 32'h0000_1234, 32'h0000_1234, 32'h2C48, 16, "R4 lsb 16-bit");
  endtask

  task automatic t_lengths();
    xfer(md(0, 0, 1, 1, 1, 8), 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32, "R2 wide 32-bit");
    xfer(md(0, 0, 1, 1, 0, 1), 32'h9000_0000, 32'h0009_0000, 32'h9, 4, "R2 clamp to 4 bits");
  endtask

  task automatic t_clock_modes();
    set_mode(md(1, 1, 1, 1, 0, 8));
    chk(32'(sck), 32'h1, "R5 idle high with polarity set");
    xfer(md(1, 1, 1, 1, 0, 8), 32'h5A00_0000, 32'h005A_0000, 32'h5A, 8, "R5 trailing-edge sample");
  endtask

  task automatic t_loopback();
    miso = 1'b0;
    xfer(md(0, 0, 1, 0, 0, 8), 32'hC100_0000, 32'h0000_0000, 32'hC1, 8, "R10 miso low no loop");
    miso = 1'b1;
    xfer(md(0, 0, 1, 0, 0, 8), 32'h0000_0000, 32'h00FF_0000, 32'h0, 8, "R10 miso high no loop");
  endtask

  task automatic t_lock();
    logic [31:0] d;
    set_mode(md(0, 0, 1, 1, 0, 8));
    bus_write(3'd0, md(1, 1, 0, 1, 0, 8) | 32'h1);
    bus_read(3'd0, d);
    chk(d, md(0, 0, 1, 1, 0, 8) | 32'h1, "R6 mode locked while enabled");
    chk(32'(sck), 32'h0, "R6 idle level unchanged");
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    set_mode(md(0, 0, 1, 1, 0, 8));
    for (int i = 1; i <= 5; i++) bus_write(3'd4, 32'(i) << 24);
    repeat (400) @(negedge clk);
    bus_read(3'd1, d);
    chk(d & 32'h6, 32'h6, "R9 overrun and data waiting");
    for (int i = 1; i <= 4; i++) begin
      bus_read(3'd5, d);
      chk(d, 32'(i) << 16, "R9 stored order");
    end
    bus_read(3'd1, d);
    chk(d & 32'h2, 32'h0, "R9 fifth character discarded");
  endtask

  task automatic t_irq_clear();
    logic [31:0] d;
    bus_write(3'd2, 32'h4);
    repeat (3) @(negedge clk);
    chk(32'(irq), 32'h1, "R11 irq on masked overrun");
    bus_write(3'd1, 32'h4);
    bus_read(3'd1, d);
    chk(d & 32'h4, 32'h0, "R8 overrun cleared by write one");
    repeat (2) @(negedge clk);
    chk(32'(irq), 32'h0, "R11 irq drops after clear");
    bus_write(3'd2, 32'h0);
  endtask

  task automatic t_underrun();
    logic [31:0] d;
    bus_read(3'd5, d);
    chk(d, 32'h0, "R8 empty read returns zero");
    bus_read(3'd1, d);
    chk(d & 32'h8, 32'h8, "R8 underrun set");
    bus_write(3'd1, 32'h3C);
  endtask

  task automatic t_select();
    bus_write(3'd6, 32'hFFFF_FFFD);
    chk(32'(ss_n), 32'hD, "R12 slave 2 selected");
    bus_write(3'd6, 32'hFFFF_FFFF);
    chk(32'(ss_n), 32'hF, "R12 all deselected");
  endtask

  task automatic t_last();
    logic [31:0] d;
    bus_write(3'd1, 32'h3C);
    set_mode(md(0, 0, 1, 1, 0, 8));
    bus_write(3'd3, 32'h1);
    bus_write(3'd4, 32'h7700_0000);
    wait_rx("R14 last transfer done");
    bus_read(3'd5, d);
    bus_read(3'd1, d);
    chk(d & 32'h20, 32'h20, "R14 last flag set");
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    set_mode(md(0, 0, 1, 1, 0, 8));
    @(negedge clk);
    ext_sel_n = 1'b0;
    @(negedge clk);
    ext_sel_n = 1'b1;
    bus_read(3'd1, d);
    chk(d & 32'h10, 32'h10, "R13 conflict flag");
    bus_read(3'd0, d);
    chk(d & 32'h1, 32'h0, "R13 enable cleared");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fail_cnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled_tx();
    t_orders();
    t_lengths();
    t_clock_modes();
    t_loopback();
    t_lock();
    t_overrun();
    t_irq_clear();
    t_underrun();
    t_select();
    t_last();
    t_conflict();
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule